// File: doc/BRIEF.md
# Prioritized Window and Pixel Color Compositor

This block forms the final color of every on-screen-display dot. Each clock it takes the current character cell (row and column), the glyph pixel and edge pixel that the upstream shifter produced for that dot, and the cell's one-bit color select. It checks the cell against three rectangular windows and picks the highest-ranked window that covers it. It then merges the glyph, the edge, the window fill and the per-row palette into an RGB triple, a fast-blank strobe that cuts the external video, and a half-tone strobe that dims the external video under a transparent window.

Each window is described by three packed registers. The first gives the row span, the second the column start with an enable and a palette-extend flag, and the third the column end with the fill color. A window whose start lies past its end is disabled. Each row supplies two palette words. The low word carries colors 1 and 2. The high word carries colors 3 and 4, which replace them when the covering window has its extend flag set. All outputs are registered once.

Top module: `osd_win_compositor`

## Requirements
- R1: While rst_n is low, pix_rgb, fblank and htone are all 0.
- R2: Outputs show the result for the inputs sampled at the previous rising clock edge. Before that edge they keep their old value.
- R3: Window k (k = 0 is the highest ranked) covers a cell when the cell row lies inclusively between row start win_rows[8k+7:8k+4] and row end win_rows[8k+3:8k].
- R4: In the same test, the cell column must lie inclusively between column start win_cs[7k+6:7k+2] and column end win_ce[8k+7:8k+3], and the enable bit win_cs[7k+1] must be 1.
- R5: A window whose row start exceeds its row end, or whose column start exceeds its column end, covers nothing, even when it is enabled.
- R6: When several windows cover a cell, the one with the lowest index supplies the fill color and the extend flag.
- R7: On a covered dot with no glyph and no edge pixel, pix_rgb is the window fill win_ce[8k+2:8k] (R in bit 2, G in bit 1, B in bit 0), and htone is 1. When neither glyph, edge nor window is present, pix_rgb, fblank and htone are 0.
- R8: On a glyph dot, pix_rgb is row_pal_lo[5:3] when cell_csel is 0 and row_pal_lo[2:0] when cell_csel is 1. htone is 0.
- R9: If the covering window has its extend bit win_cs[7k] set, a glyph dot takes row_pal_hi[5:3] or row_pal_hi[2:0] instead, chosen by cell_csel in the same way.
- R10: An edge dot with no glyph outputs pix_rgb = 0 with fblank = 1 and htone = 0.
- R11: fblank is 1 on glyph or edge dots. It is also 1 on window-only dots when fb_chars_only is 0, and 0 on those dots when fb_chars_only is 1.
- R12: When osd_en is 0, pix_rgb, fblank and htone are 0 one clock later, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_row | input | 4 | Character row of the current dot |
| cell_col | input | 5 | Character column of the current dot |
| glyph_px | input | 1 | Glyph (luminance) pixel |
| edge_px | input | 1 | Border or shadow pixel |
| cell_csel | input | 1 | Per-cell color select |
| row_pal_lo | input | 6 | Row colors 1 ([5:3]) and 2 ([2:0]) |
| row_pal_hi | input | 6 | Row colors 3 ([5:3]) and 4 ([2:0]) |
| win_rows | input | 24 | Row start/end, one byte per window |
| win_cs | input | 21 | Column start, enable and extend, 7 bits per window |
| win_ce | input | 24 | Column end and fill RGB, one byte per window |
| osd_en | input | 1 | Global display enable |
| fb_chars_only | input | 1 | Fast-blank only on characters when 1 |
| pix_rgb | output | 3 | Registered color, R in bit 2 |
| fblank | output | 1 | Registered fast-blank |
| htone | output | 1 | Registered half-tone |

## Verification
The hardest case to reach from the ports is a three-way overlap in which the lower-ranked windows differ from the winner in both fill color and extend flag, while one or more windows are enabled but inverted along only one axis. Uniformly random registers seldom produce this. The stimulus therefore draws coordinates from the small on-screen range so that windows overlap often and inversions happen at a useful rate. It also adds directed cases that stack all three windows on one cell, disable them one at a time, invert only the row span or only the column span, and probe the inclusive corners and the cells one step outside them.

// File: rtl/osd_comp_pkg.sv
package osd_comp_pkg;

  // Width of the per-dot color triple
  localparam int unsigned RGB_W = 3;

  typedef logic [RGB_W-1:0] rgb_t;

  // Registered output bundle of the compositor
  typedef struct packed {
    rgb_t rgb;
    logic fblank;
    logic htone;
  } pix_out_t;

  localparam pix_out_t PIX_IDLE = '{rgb: '0, fblank: 1'b0, htone: 1'b0};

  // Inclusive span test with disable-on-inversion
  function automatic logic in_span(input logic [7:0] lo, input logic [7:0] hi,
                                   input logic [7:0] pos);
    return (lo <= hi) && (pos >= lo) && (pos <= hi);
  endfunction

endpackage

// File: rtl/osd_win_hit.sv
module osd_win_hit
  import osd_comp_pkg::*;
#(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned COL_W = 5,
  localparam int unsigned RREG_W = 2 * ROW_W,
  localparam int unsigned SREG_W = COL_W + 2,
  localparam int unsigned EREG_W = COL_W + RGB_W
) (
  input  logic [ROW_W-1:0]  cell_row,
  input  logic [COL_W-1:0]  cell_col,
  input  logic [RREG_W-1:0] reg_rows,
  input  logic [SREG_W-1:0] reg_cs,
  input  logic [EREG_W-1:0] reg_ce,
  output logic              hit,
  output logic              ext,
  output rgb_t              fill
);

  logic [ROW_W-1:0] row_lo;
  logic [ROW_W-1:0] row_hi;
  logic [COL_W-1:0] col_lo;
  logic [COL_W-1:0] col_hi;
  logic             win_on;
  logic             row_ok;
  logic             col_ok;

  // Field extraction from the packed window registers
  always_comb begin
    row_lo = reg_rows[RREG_W-1 -: ROW_W];
    row_hi = reg_rows[ROW_W-1:0];
    col_lo = reg_cs[SREG_W-1 -: COL_W];
    win_on = reg_cs[1];
    col_hi = reg_ce[EREG_W-1 -: COL_W];
    fill   = reg_ce[RGB_W-1:0];
    ext    = reg_cs[0];
  end

  // Inclusive rectangle test; an inverted span on either axis disables it
  always_comb begin
    row_ok = in_span(8'(row_lo), 8'(row_hi), 8'(cell_row));
    col_ok = in_span(8'(col_lo), 8'(col_hi), 8'(cell_col));
    hit    = win_on && row_ok && col_ok;
  end

endmodule

// File: rtl/osd_win_prio.sv
module osd_win_prio
  import osd_comp_pkg::*;
#(
  parameter int unsigned NUM_WIN = 3
) (
  input  logic [NUM_WIN-1:0]       hit,
  input  logic [NUM_WIN-1:0]       ext,
  input  logic [NUM_WIN*RGB_W-1:0] fill,
  output logic                     any_hit,
  output logic                     sel_ext,
  output rgb_t                     sel_fill
);

  // Lowest index has the highest rank: scan from the bottom up so
  // that a higher-ranked hit overrides whatever came before it.
  always_comb begin
    any_hit  = 1'b0;
    sel_ext  = 1'b0;
    sel_fill = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit  = 1'b1;
        sel_ext  = ext[i];
        sel_fill = fill[i*RGB_W +: RGB_W];
      end
    end
  end

endmodule

// File: rtl/osd_pix_mix.sv
module osd_pix_mix
  import osd_comp_pkg::*;
#(
  localparam int unsigned PAL_W = 2 * RGB_W
) (
  input  logic             glyph_px,
  input  logic             edge_px,
  input  logic             cell_csel,
  input  logic [PAL_W-1:0] row_pal_lo,
  input  logic [PAL_W-1:0] row_pal_hi,
  input  logic             win_any,
  input  logic             win_ext,
  input  rgb_t             win_fill,
  input  logic             osd_en,
  input  logic             fb_chars_only,
  output pix_out_t         pix_nxt
);

  logic [PAL_W-1:0] pal;
  rgb_t             chr_rgb;
  logic             on_char;

  always_comb begin
    pal     = (win_any && win_ext) ? row_pal_hi : row_pal_lo;
    chr_rgb = cell_csel ? pal[RGB_W-1:0] : pal[PAL_W-1 -: RGB_W];
    on_char = glyph_px || edge_px;
  end

  // Layering: glyph over edge over window over background
  always_comb begin
    pix_nxt = PIX_IDLE;
    if (osd_en) begin
      if (glyph_px) begin
        pix_nxt.rgb    = chr_rgb;
        pix_nxt.fblank = 1'b1;
      end else if (edge_px) begin
        pix_nxt.rgb    = '0;
        pix_nxt.fblank = 1'b1;
      end else if (win_any) begin
        pix_nxt.rgb    = win_fill;
        pix_nxt.fblank = !fb_chars_only;
        pix_nxt.htone  = 1'b1;
      end
      if (on_char) begin
        pix_nxt.htone = 1'b0;
      end
    end
  end

endmodule

// File: rtl/osd_win_compositor.sv
module osd_win_compositor
  import osd_comp_pkg::*;
#(
  parameter int unsigned NUM_WIN = 3,
  parameter int unsigned ROW_W   = 4,
  parameter int unsigned COL_W   = 5,
  localparam int unsigned RREG_W = 2 * ROW_W,
  localparam int unsigned SREG_W = COL_W + 2,
  localparam int unsigned EREG_W = COL_W + RGB_W,
  localparam int unsigned PAL_W  = 2 * RGB_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ROW_W-1:0]          cell_row,
  input  logic [COL_W-1:0]          cell_col,
  input  logic                      glyph_px,
  input  logic                      edge_px,
  input  logic                      cell_csel,
  input  logic [PAL_W-1:0]          row_pal_lo,
  input  logic [PAL_W-1:0]          row_pal_hi,
  input  logic [NUM_WIN*RREG_W-1:0] win_rows,
  input  logic [NUM_WIN*SREG_W-1:0] win_cs,
  input  logic [NUM_WIN*EREG_W-1:0] win_ce,
  input  logic                      osd_en,
  input  logic                      fb_chars_only,
  output logic [RGB_W-1:0]          pix_rgb,
  output logic                      fblank,
  output logic                      htone
);

  logic [NUM_WIN-1:0]       hit_vec;
  logic [NUM_WIN-1:0]       ext_vec;
  logic [NUM_WIN*RGB_W-1:0] fill_vec;
  logic                     win_any;
  logic                     win_ext;
  rgb_t                     win_fill;
  pix_out_t                 pix_nxt;
  pix_out_t                 pix_q;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      osd_win_hit #(
        .ROW_W(ROW_W),
        .COL_W(COL_W)
      ) hit_i (
        .cell_row (cell_row),
        .cell_col (cell_col),
        .reg_rows (win_rows[w*RREG_W +: RREG_W]),
        .reg_cs   (win_cs[w*SREG_W +: SREG_W]),
        .reg_ce   (win_ce[w*EREG_W +: EREG_W]),
        .hit      (hit_vec[w]),
        .ext      (ext_vec[w]),
        .fill     (fill_vec[w*RGB_W +: RGB_W])
      );
    end
  endgenerate

  osd_win_prio #(
    .NUM_WIN(NUM_WIN)
  ) prio_i (
    .hit      (hit_vec),
    .ext      (ext_vec),
    .fill     (fill_vec),
    .any_hit  (win_any),
    .sel_ext  (win_ext),
    .sel_fill (win_fill)
  );

  osd_pix_mix mix_i (
    .glyph_px      (glyph_px),
    .edge_px       (edge_px),
    .cell_csel     (cell_csel),
    .row_pal_lo    (row_pal_lo),
    .row_pal_hi    (row_pal_hi),
    .win_any       (win_any),
    .win_ext       (win_ext),
    .win_fill      (win_fill),
    .osd_en        (osd_en),
    .fb_chars_only (fb_chars_only),
    .pix_nxt       (pix_nxt)
  );

  // Output register, one dot of latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= PIX_IDLE;
    end else begin
      pix_q <= pix_nxt;
    end
  end

  assign pix_rgb = pix_q.rgb;
  assign fblank  = pix_q.fblank;
  assign htone   = pix_q.htone;

endmodule

// File: rtl/osd_win_compositor_chk.sv
module osd_win_compositor_chk #(
  parameter int unsigned RGB_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glyph_px,
  input logic             edge_px,
  input logic             osd_en,
  input logic             fb_chars_only,
  input logic [RGB_W-1:0] pix_rgb,
  input logic             fblank,
  input logic             htone
);

  // R12: disabled display yields dark, unblanked output next dot
  p_off_dark_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !osd_en |=> (pix_rgb == '0 && !fblank && !htone));

  // R10: edge-only dot is black and blanked
  p_edge_black_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (osd_en && edge_px && !glyph_px) |=> (pix_rgb == '0 && fblank && !htone));

  // R8: glyph dots never raise half-tone
  p_glyph_no_ht_r8: assert property (@(posedge clk) disable iff (!rst_n)
    glyph_px |=> !htone);

  // R11: characters-only mode leaves window-only dots unblanked
  p_fb_chars_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (osd_en && fb_chars_only && !glyph_px && !edge_px) |=> !fblank);

  // R11: in full mode a half-tone dot is always blanked
  p_ht_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (osd_en && !fb_chars_only) |=> (!htone || fblank));

endmodule

bind osd_win_compositor osd_win_compositor_chk #(
  .RGB_W(osd_comp_pkg::RGB_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .glyph_px      (glyph_px),
  .edge_px       (edge_px),
  .osd_en        (osd_en),
  .fb_chars_only (fb_chars_only),
  .pix_rgb       (pix_rgb),
  .fblank        (fblank),
  .htone         (htone)
);

// File: tb/osd_win_compositor_tb_top.sv
module osd_win_compositor_tb_top;

  localparam int NW = 3;

  logic        clk;
  logic        rst_n;
  logic [3:0]  cell_row;
  logic [4:0]  cell_col;
  logic        glyph_px;
  logic        edge_px;
  logic        cell_csel;
  logic [5:0]  row_pal_lo;
  logic [5:0]  row_pal_hi;
  logic [23:0] win_rows;
  logic [20:0] win_cs;
  logic [23:0] win_ce;
  logic        osd_en;
  logic        fb_chars_only;
  logic [2:0]  pix_rgb;
  logic        fblank;
  logic        htone;

  int total;
  int bad;
  logic [4:0] exp_q;

  osd_win_compositor dut_i (
    .clk(clk), .rst_n(rst_n), .cell_row(cell_row), .cell_col(cell_col),
    .glyph_px(glyph_px), .edge_px(edge_px), .cell_csel(cell_csel),
    .row_pal_lo(row_pal_lo), .row_pal_hi(row_pal_hi), .win_rows(win_rows),
    .win_cs(win_cs), .win_ce(win_ce), .osd_en(osd_en),
    .fb_chars_only(fb_chars_only), .pix_rgb(pix_rgb), .fblank(fblank),
    .htone(htone)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference: {rgb, fblank, htone} from the requirements
  function automatic logic [4:0] model();
    logic       any = 1'b0;
    logic       x   = 1'b0;
    logic [2:0] c   = 3'd0;
    logic [5:0] pal;
    logic [2:0] chr;
    for (int k = 0; k < NW; k++) begin
      int rs = win_rows[8*k+4 +: 4];
      int re = win_rows[8*k +: 4];
      int cs = win_cs[7*k+2 +: 5];
      int ce = win_ce[8*k+3 +: 5];
      if (!any && win_cs[7*k+1] && rs <= re && cs <= ce &&
          cell_row >= rs && cell_row <= re && cell_col >= cs && cell_col <= ce) begin
        any = 1'b1;
        x   = win_cs[7*k];
        c   = win_ce[8*k +: 3];
      end
    end
    if (!osd_en) return 5'd0;
    pal = (any && x) ? row_pal_hi : row_pal_lo;
    chr = cell_csel ? pal[2:0] : pal[5:3];
    if (glyph_px) return {chr, 2'b10};
    if (edge_px)  return {3'b000, 2'b10};
    if (any)      return {c, !fb_chars_only, 1'b1};
    return 5'd0;
  endfunction

  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] got = {pix_rgb, fblank, htone};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  // Inputs already driven at a falling edge; one rising edge later, check
  task automatic step(input string tag);
    exp_q = model();
    @(negedge clk);
    check(tag, exp_q);
  endtask

  task automatic set_win(input int k, input int rs, input int re, input int cs,
                         input int ce, input bit on, input bit x, input logic [2:0] c);
    win_rows[8*k +: 8] = {4'(rs), 4'(re)};
    win_cs[7*k +: 7]   = {5'(cs), on, x};
    win_ce[8*k +: 8]   = {5'(ce), c};
  endtask

  task automatic at(input int r, input int c, input bit g, input bit e, input bit s);
    cell_row = 4'(r); cell_col = 5'(c); glyph_px = g; edge_px = e; cell_csel = s;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    total = 0; bad = 0;
    rst_n = 1'b0;
    at(0, 0, 1, 0, 0);
    row_pal_lo = 6'o75; row_pal_hi = 6'o31;
    win_rows = '0; win_cs = '0; win_ce = '0;
    osd_en = 1'b1; fb_chars_only = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", 5'd0);
    rst_n = 1'b1;
    step("R8 glyph csel0");

    // R2: old value held until the next rising edge
    at(0, 0, 1, 0, 1);
    #2 check("R2 hold before edge", {3'o7, 2'b10});
    step("R2 after one edge");

    // R3/R4 inclusive corners of one window
    set_win(1, 2, 5, 4, 9, 1, 0, 3'o3);
    at(2, 4, 0, 0, 0); step("R3 top-left corner");
    at(5, 9, 0, 0, 0); step("R4 bottom-right corner");
    at(6, 9, 0, 0, 0); step("R3 row past end");
    at(5, 10, 0, 0, 0); step("R4 col past end");
    at(1, 4, 0, 0, 0); step("R3 row before start");
    set_win(1, 2, 5, 4, 9, 0, 0, 3'o3);
    at(3, 5, 0, 0, 0); step("R4 enable off");

    // R5 inversion on one axis only
    set_win(1, 5, 2, 4, 9, 1, 0, 3'o3);
    at(3, 5, 0, 0, 0); step("R5 row inverted");
    set_win(1, 2, 5, 9, 4, 1, 0, 3'o3);
    at(3, 5, 0, 0, 0); step("R5 col inverted");
    set_win(1, 3, 3, 5, 5, 1, 0, 3'o3);
    at(3, 5, 0, 0, 0); step("R5 equal bounds");

    // R6 stacking of three windows, peeled one by one
    set_win(0, 0, 9, 0, 23, 1, 1, 3'o1);
    set_win(1, 0, 9, 0, 23, 1, 0, 3'o2);
    set_win(2, 0, 9, 0, 23, 1, 1, 3'o4);
    at(4, 7, 0, 0, 0); step("R6 win0 wins");
    at(4, 7, 1, 0, 0); step("R9 extend from win0");
    set_win(0, 0, 9, 0, 23, 0, 1, 3'o1);
    at(4, 7, 0, 0, 0); step("R6 win1 wins");
    at(4, 7, 1, 0, 1); step("R8 no extend from win1");
    set_win(1, 9, 0, 0, 23, 1, 0, 3'o2);
    at(4, 7, 0, 0, 0); step("R6 win2 wins");
    at(4, 7, 1, 0, 1); step("R9 extend csel1");

    // R7 window fill and half-tone; empty background
    at(4, 7, 0, 0, 0); step("R7 fill htone");
    set_win(2, 0, 9, 0, 23, 0, 0, 3'o4);
    at(4, 7, 0, 0, 0); step("R7 background");

    // R10 edge over window
    set_win(0, 0, 9, 0, 23, 1, 0, 3'o6);
    at(1, 1, 0, 1, 0); step("R10 edge black");

    // R11 fast-blank mode
    fb_chars_only = 1'b1;
    at(1, 1, 0, 0, 0); step("R11 window only chars mode");
    at(1, 1, 1, 0, 0); step("R11 glyph chars mode");
    fb_chars_only = 1'b0;
    at(1, 1, 0, 0, 0); step("R11 window full mode");

    // R12 display off
    osd_en = 1'b0;
    at(1, 1, 1, 1, 1); step("R12 off glyph");
    at(1, 1, 0, 0, 0); step("R12 off window");
    osd_en = 1'b1;

    // Random traffic biased to the visible range
    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < NW; k++) begin
        set_win(k, $urandom_range(10), $urandom_range(10), $urandom_range(23),
                $urandom_range(23), ($urandom_range(3) != 0), $urandom_range(1),
                3'($urandom));
      end
      row_pal_lo = 6'($urandom); row_pal_hi = 6'($urandom);
      at($urandom_range(10), $urandom_range(23), ($urandom_range(3) == 0),
         ($urandom_range(3) == 0), $urandom_range(1));
      osd_en = ($urandom_range(7) != 0);
      fb_chars_only = $urandom_range(1);
      step("R6 random");
    end

    finish_run();
  end

endmodule